// File: doc/BRIEF.md
# EEPROM status register and write-protect arbiter

This block keeps the status byte of a serial EEPROM and rules on every write the device is asked to perform. A serial front end hands it decoded command pulses (enable writes, disable writes, write status with its data byte), the chip-select level, the hardware write-protect pin and the address of the byte currently being loaded. The block answers with the byte to shift out for a status read and with two permit lines: one for a status write and one for the array byte at the presented address.

The front end also reports when an internal programming cycle begins (`arr_start_i` for an array write) and when any internal cycle ends (`wr_done_i`). A status write is held pending while chip select stays low and commits when chip select rises, starting an internal cycle of its own. The protect-enable bit and both block-protect bits model non-volatile storage: they are plain flops with no reset, so they survive `rst_ni`. Array bytes are judged one at a time, so the part of a page that lands in a protected range is refused without affecting the rest.

Top module: `eeprom_wprot_ctrl`

## Requirements
- R1: After reset the ready bit (bit 0) and the write-enable bit (bit 1) read 0. Outside a busy cycle the status byte is {protect-enable at bit 7, 0 at bits 6..4, block-protect high at bit 3, block-protect low at bit 2, write-enable at bit 1, 0 at bit 0}.
- R2: An enable-writes pulse sets the write-enable bit and a disable-writes pulse clears it. Both are ignored while an internal cycle runs.
- R3: While an internal cycle runs, `busy_o` is 1 and the status byte reads 0xFF.
- R4: A completed status write changes only bits 7, 3 and 2. All other bits of the data byte have no effect.
- R5: A status write is permitted only when the write-enable bit is 1, no cycle runs, and hardware lock is off. Hardware lock means protect-enable is 1 and `wp_i` is 0. A refused status write starts no cycle and changes nothing.
- R6: If hardware lock comes on while a status write is pending and chip select is still low, the write is dropped. Once its internal cycle has begun, `wp_i` has no effect on it.
- R7: Block-protect code 00 locks no address, 01 locks 0x3000-0x3FFF, 10 locks 0x2000-0x3FFF and 11 locks every address. These are the upper quarter, the upper half and the whole of the 14-bit space.
- R8: An array byte is permitted only when the write-enable bit is 1, no cycle runs, and its address is outside the locked range. Hardware lock does not affect unlocked array addresses.
- R9: The end of any internal cycle clears the write-enable bit and `busy_o`. A status cycle begins in the cycle after chip select rises with a write pending.
- R10: Protect-enable and the block-protect bits keep their values through `rst_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip-select level, active low |
| wp_i | input | 1 | Hardware write-protect pin, low locks |
| wren_i | input | 1 | Enable-writes command pulse |
| wrdi_i | input | 1 | Disable-writes command pulse |
| wrsr_i | input | 1 | Status-write command pulse, data valid |
| wrsr_data_i | input | 8 | Data byte of the status write |
| arr_start_i | input | 1 | Internal array programming cycle begins |
| wr_done_i | input | 1 | Internal cycle ends |
| addr_i | input | ADDR_W | Address of the array byte being judged |
| status_o | output | 8 | Byte returned for a status read |
| busy_o | output | 1 | Internal cycle in progress |
| status_wr_ok_o | output | 1 | A status write would be accepted now |
| array_wr_ok_o | output | 1 | The byte at `addr_i` may be written |

## Verification
The assertions assume that the front end raises `wrsr_i` only while chip select is low, and only after checking `status_wr_ok_o`. They also assume that `wr_done_i` arrives only while a cycle runs and that `arr_start_i` never coincides with a pending status write. The directed tasks keep to this: each status write is framed by a falling and a rising chip select, and completion pulses follow a busy window. The bench clears the non-volatile bits through a permitted status write before it checks their value, because they power up undefined.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int unsigned SR_WPEN = 7;
  localparam int unsigned SR_BPH  = 3;
  localparam int unsigned SR_BPL  = 2;
  localparam int unsigned SR_WEL  = 1;
  localparam int unsigned SR_RDY  = 0;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bp;
  } nv_bits_t;

  function automatic logic [7:0] pack_status(nv_bits_t nv, logic wel);
    logic [7:0] s;
    s         = '0;
    s[SR_WPEN] = nv.wpen;
    s[SR_BPH]  = nv.bp[1];
    s[SR_BPL]  = nv.bp[0];
    s[SR_WEL]  = wel;
    s[SR_RDY]  = 1'b0;
    return s;
  endfunction
endpackage

// File: rtl/sr_block_decode.sv
module sr_block_decode #(
  parameter int unsigned ADDR_W = 14
) (
  input  logic [1:0]        bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              locked_o
);
  localparam int unsigned TOP = ADDR_W - 1;

  always_comb begin
    unique case (bp_i)
      2'b00:   locked_o = 1'b0;
      2'b01:   locked_o = &addr_i[TOP -: 2];
      2'b10:   locked_o = addr_i[TOP];
      default: locked_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sr_wel_latch.sv
module sr_wel_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic busy_i,
  input  logic done_i,
  output logic wel_o
);
  logic wel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                wel_q <= 1'b0;
    else if (busy_i && done_i)  wel_q <= 1'b0;
    else if (!busy_i && clr_i)  wel_q <= 1'b0;
    else if (!busy_i && set_i)  wel_q <= 1'b1;
  end

  assign wel_o = wel_q;

  p_wel_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_q) |-> $past(set_i) && !$past(busy_i));
  p_wel_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && done_i |=> !wel_q);
endmodule

// File: rtl/sr_nv_store.sv
module sr_nv_store
  import sr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_i,
  input  nv_bits_t data_i,
  input  logic     permit_i,
  input  logic     cs_n_i,
  input  logic     hw_lock_i,
  input  logic     busy_i,
  input  logic     done_i,
  output logic     start_o,
  output nv_bits_t nv_o
);
  logic     pend_q, st_cyc_q;
  nv_bits_t stage_q, nv_q;

  assign start_o = pend_q && cs_n_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      st_cyc_q <= 1'b0;
      stage_q  <= '0;
    end else begin
      if (pend_q && !cs_n_i && hw_lock_i) pend_q <= 1'b0;   // lock while selected: abort
      else if (start_o)                   pend_q <= 1'b0;
      else if (req_i && permit_i)         pend_q <= 1'b1;
      if (req_i && permit_i) stage_q <= data_i;
      if (start_o)                st_cyc_q <= 1'b1;
      else if (busy_i && done_i)  st_cyc_q <= 1'b0;
    end
  end

  // non-volatile bits: no reset
  always_ff @(posedge clk_i) begin
    if (st_cyc_q && busy_i && done_i) nv_q <= stage_q;
  end

  assign nv_o = nv_q;

  p_abort_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !cs_n_i && hw_lock_i |=> !pend_q && !start_o);
  p_nv_only_on_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_cyc_q && busy_i && done_i) |=> $stable(nv_q));
endmodule

// File: rtl/eeprom_wprot_ctrl.sv
module eeprom_wprot_ctrl
  import sr_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              wp_i,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              arr_start_i,
  input  logic              wr_done_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        status_o,
  output logic              busy_o,
  output logic              status_wr_ok_o,
  output logic              array_wr_ok_o
);
  logic     busy_q, wel, locked, hw_lock, st_start;
  nv_bits_t nv, wr_bits;
  logic     unused_data;

  assign unused_data = ^{wrsr_data_i[6:4], wrsr_data_i[1:0]};
  assign wr_bits = '{wpen: wrsr_data_i[SR_WPEN],
                     bp:   {wrsr_data_i[SR_BPH], wrsr_data_i[SR_BPL]}};

  assign hw_lock = nv.wpen && !wp_i;

  sr_wel_latch u_wel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wren_i),
    .clr_i  (wrdi_i),
    .busy_i (busy_q),
    .done_i (wr_done_i),
    .wel_o  (wel)
  );

  sr_nv_store u_nv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (wrsr_i),
    .data_i    (wr_bits),
    .permit_i  (status_wr_ok_o),
    .cs_n_i    (cs_n_i),
    .hw_lock_i (hw_lock),
    .busy_i    (busy_q),
    .done_i    (wr_done_i),
    .start_o   (st_start),
    .nv_o      (nv)
  );

  sr_block_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bp_i     (nv.bp),
    .addr_i   (addr_i),
    .locked_o (locked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          busy_q <= 1'b0;
    else if (busy_q && wr_done_i)         busy_q <= 1'b0;
    else if (st_start)                    busy_q <= 1'b1;
    else if (!busy_q && arr_start_i)      busy_q <= 1'b1;
  end

  assign busy_o         = busy_q;
  assign status_o       = busy_q ? 8'hFF : pack_status(nv, wel);
  assign status_wr_ok_o = wel && !busy_q && !hw_lock;
  assign array_wr_ok_o  = wel && !busy_q && !locked;

  p_busy_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !array_wr_ok_o && !status_wr_ok_o);
  p_busy_reads_ff_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> status_o == 8'hFF);
  p_lock_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv.wpen && !wp_i |-> !status_wr_ok_o);
  p_zero_bits_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> status_o[6:4] == 3'b000 && !status_o[SR_RDY]);
  p_full_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv.bp == 2'b11 |-> !array_wr_ok_o);
endmodule

// File: tb/eeprom_wprot_ctrl_tb_top.sv
module eeprom_wprot_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wp = 1'b1, wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0;
  logic [7:0]  wrsr_data = 8'h00;
  logic        arr_start = 1'b0, wr_done = 1'b0;
  logic [13:0] addr = '0;
  logic [7:0]  status;
  logic        busy, st_ok, arr_ok;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  eeprom_wprot_ctrl #(.ADDR_W(14)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .wp_i(wp),
    .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr), .wrsr_data_i(wrsr_data),
    .arr_start_i(arr_start), .wr_done_i(wr_done), .addr_i(addr),
    .status_o(status), .busy_o(busy), .status_wr_ok_o(st_ok), .array_wr_ok_o(arr_ok)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_wren;
    @(negedge clk) wren = 1'b1;
    @(negedge clk) wren = 1'b0;
  endtask

  task automatic send_wrdi;
    @(negedge clk) wrdi = 1'b1;
    @(negedge clk) wrdi = 1'b0;
  endtask

  // full status-write frame; busy_seen sampled in the cycle after CS rises
  task automatic do_wrsr(input logic [7:0] d, output logic busy_seen);
    send_wren();
    @(negedge clk) cs_n = 1'b0; wrsr = 1'b1; wrsr_data = d;
    @(negedge clk) wrsr = 1'b0; cs_n = 1'b1;
    @(negedge clk) busy_seen = busy;
    wr_done = 1'b1;
    @(negedge clk) wr_done = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset wel/rdy", status & 8'h03, 8'h00);
    chk("R1 reset busy", {7'd0, busy}, 8'h00);
  endtask

  task automatic t_wel;
    logic b;
    send_wren();
    chk("R2 wren sets wel", status & 8'h02, 8'h02);
    send_wrdi();
    chk("R2 wrdi clears wel", status & 8'h02, 8'h00);
    do_wrsr(8'hFF, b);
    chk("R4 write-status all ones", status, 8'h8C);
    chk("R9 wel cleared by completion", status & 8'h02, 8'h00);
    do_wrsr(8'h73, b);
    chk("R4 bits 6..4,1,0 ignored", status, 8'h00);
  endtask

  task automatic t_busy;
    send_wren();
    @(negedge clk) arr_start = 1'b1;
    @(negedge clk) arr_start = 1'b0;
    chk("R3 busy flag", {7'd0, busy}, 8'h01);
    chk("R3 status reads FF", status, 8'hFF);
    chk("R8 no permit while busy", {6'd0, st_ok, arr_ok}, 8'h00);
    send_wrdi();
    send_wren();
    @(negedge clk) wr_done = 1'b1;
    @(negedge clk) wr_done = 1'b0;
    chk("R9 busy cleared", {7'd0, busy}, 8'h00);
    chk("R2 wren/wrdi ignored while busy, wel 0", status, 8'h00);
  endtask

  task automatic t_hw_lock;
    logic b;
    do_wrsr(8'h84, b);
    chk("R4 set wpen bp=01", status, 8'h84);
    @(negedge clk) wp = 1'b0;
    chk("R5 no wel no permit", {7'd0, st_ok}, 8'h00);
    send_wren();
    chk("R5 hw lock refuses status write", {7'd0, st_ok}, 8'h00);
    @(negedge clk) addr = 14'h1000;
    @(negedge clk);
    chk("R8 unlocked addr writable under hw lock", {7'd0, arr_ok}, 8'h01);
    @(negedge clk) addr = 14'h3000;
    @(negedge clk);
    chk("R7 bp01 locks 0x3000", {7'd0, arr_ok}, 8'h00);
    @(negedge clk) addr = 14'h2FFF;
    @(negedge clk);
    chk("R7 bp01 leaves 0x2FFF", {7'd0, arr_ok}, 8'h01);
    do_wrsr(8'h00, b);
    chk("R5 refused write starts no cycle", {7'd0, b}, 8'h00);
    chk("R5 refused write keeps status", status, 8'h86);
    send_wrdi();
    @(negedge clk) wp = 1'b1;
  endtask

  task automatic t_bp;
    logic b;
    do_wrsr(8'h08, b);
    send_wren();
    @(negedge clk) addr = 14'h1FFF;
    @(negedge clk);
    chk("R7 bp10 leaves 0x1FFF", {7'd0, arr_ok}, 8'h01);
    @(negedge clk) addr = 14'h2000;
    @(negedge clk);
    chk("R7 bp10 locks 0x2000", {7'd0, arr_ok}, 8'h00);
    send_wrdi();
    chk("R8 no wel no array permit", {7'd0, arr_ok}, 8'h00);
    do_wrsr(8'h0C, b);
    send_wren();
    @(negedge clk) addr = 14'h0000;
    @(negedge clk);
    chk("R7 bp11 locks 0x0000", {7'd0, arr_ok}, 8'h00);
    send_wrdi();
    do_wrsr(8'h00, b);
    send_wren();
    @(negedge clk) addr = 14'h3FFF;
    @(negedge clk);
    chk("R7 bp00 leaves 0x3FFF", {7'd0, arr_ok}, 8'h01);
    send_wrdi();
  endtask

  task automatic t_abort;
    logic b;
    do_wrsr(8'h80, b);
    send_wren();
    @(negedge clk) cs_n = 1'b0; wrsr = 1'b1; wrsr_data = 8'h8C;
    @(negedge clk) wrsr = 1'b0; wp = 1'b0;
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
    chk("R6 wp fall with cs low aborts", {7'd0, busy}, 8'h00);
    chk("R6 aborted write leaves status", status, 8'h82);
    @(negedge clk) wp = 1'b1;
    @(negedge clk) cs_n = 1'b0; wrsr = 1'b1; wrsr_data = 8'h88;
    @(negedge clk) wrsr = 1'b0; cs_n = 1'b1;
    @(negedge clk) wp = 1'b0;
    chk("R9 status cycle started", {7'd0, busy}, 8'h01);
    @(negedge clk) wr_done = 1'b1;
    @(negedge clk) wr_done = 1'b0;
    chk("R6 wp ignored once cycle runs", status, 8'h88);
    @(negedge clk) wp = 1'b1;
  endtask

  task automatic t_retain;
    send_wren();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R10 nv bits kept, wel reset", status, 8'h88);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_wel();
        t_busy();
        t_hw_lock();
        t_bp();
        t_abort();
        t_retain();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule